// File: doc/BRIEF.md
# Serial-Loaded Bank Control Register File

This block turns a stream of one-bit processor writes into four 5-bit bank control registers and decodes them into memory bank selections. Each accepted write adds data bit 0 to a shift buffer, least significant bit first. The fifth accepted write commits the assembled value to the register chosen by address bits 14:13. A write with data bit 7 set abandons any partial load instead.

The decoded outputs are:
- the program-space mapping: either one 32K window or two 16K windows, one of them fixed;
- the pattern-space mapping: either two 4K banks or one 8K bank;
- a 2-bit nametable mirroring code.

The block only accepts data writes when the external mode value selects it (mode bit 1 set). A separate mode-register write strobe carries address bit 0. When that bit is set, the strobe restores the control register, clears the program register and drops any partial load.

Top module: `serialBankRegs`

## Requirements
- R1: After reset, the outputs reflect control = 0x0C and registers 1 to 3 = 0: `prgIs32k`=0, `prgLoBank`=0, `prgHiBank`=15, `patIs4k`=0, `pat8kBank`=0, `patLoBank`=0, `patHiBank`=1, `mirrorSel`=0. The shift buffer and bit count are empty.
- R2: An accepted write with data bit 7 set empties the shift buffer and bit count and sets control bits 2 and 3. Control bits 0, 1 and 4 are kept.
- R3: Accepted writes with data bit 7 clear shift in data bit 0, first bit into register bit 0. No output changes until the fifth such write, after which the buffer and count are empty again.
- R4: On the fifth bit, address bits 14:13 pick the target: 0 = control (0x8000), 1 = pattern-low register (0xA000), 2 = pattern-high register (0xC000), 3 = program register (0xE000).
- R5: With control bit 3 clear, `prgIs32k`=1 and `prg32kBank` = program register bits 3:1; `prgLoBank`/`prgHiBank` show the two 16K halves of that window.
- R6: With control bit 3 set, `prgIs32k`=0. Control bit 2 set gives low window = program register bits 3:0 and high window = 15. Control bit 2 clear gives low window = 0 and high window = program register bits 3:0.
- R7: Control bit 4 set gives `patIs4k`=1, `patLoBank` = register 1, `patHiBank` = register 2. Bit 4 clear gives `patIs4k`=0, `pat8kBank` = register 1 bits 4:1, `patLoBank`/`patHiBank` = that bank times 2, plus 0 and plus 1.
- R8: `mirrorSel` equals control bits 1:0: 0 one-screen low, 1 one-screen high, 2 vertical, 3 horizontal.
- R9: A mode write with `modeWrA0`=1 sets control to 0x0C, clears the program register and empties the shift buffer and count. A mode write with `modeWrA0`=0 changes none of them.
- R10: Data writes while `modeSel` bit 1 is clear (mode 0 or 1) change neither the buffer, the count nor any register.
- R11: When a mode write with `modeWrA0`=1 and a data write arrive in the same cycle, the data write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Data write strobe, one cycle per write |
| busAddr | input | 16 | Write address; bits 14:13 pick the register |
| busData | input | 8 | Write data; bit 7 aborts, bit 0 is the serial bit |
| modeSel | input | 2 | Current mode value; the block accepts writes when bit 1 is set |
| modeWrEn | input | 1 | Mode-register write strobe |
| modeWrA0 | input | 1 | Address bit 0 of the mode-register write |
| prgIs32k | output | 1 | 1 when program space is one 32K window |
| prg32kBank | output | 3 | 32K program bank |
| prgLoBank | output | 4 | 16K bank in the low program window |
| prgHiBank | output | 4 | 16K bank in the high program window |
| patIs4k | output | 1 | 1 when pattern space uses two 4K banks |
| pat8kBank | output | 4 | 8K pattern bank |
| patLoBank | output | 5 | 4K bank in the low pattern half |
| patHiBank | output | 5 | 4K bank in the high pattern half |
| mirrorSel | output | 2 | Mirroring code |

## Verification
The bit count cannot be seen at the ports. A count left non-zero by an abort, a mode write or an ignored write therefore stays hidden until the next load. On the fifth write of that load, the value lands one or more writes early or late, with its bits shifted. The stimulus puts a full 5-bit load directly after every partial sequence, so such a slip shows in the next committed value. A wrong register bit shows on the decoded outputs one cycle after the commit write.

// File: rtl/serialBankPkg.sv
package serialBankPkg;
  localparam int unsigned SB_REG_W  = 5;
  localparam int unsigned SB_NREGS  = 4;
  localparam int unsigned SB_CNT_W  = $clog2(SB_REG_W + 1);
  localparam int unsigned SB_IDX_W  = $clog2(SB_NREGS);
  localparam logic [SB_REG_W-1:0] SB_CTRL_RST = 5'h0C;

  typedef struct packed {
    logic                hardClr;
    logic                softRst;
    logic                shiftEn;
    logic                commit;
    logic [SB_CNT_W-1:0] bitPos;
    logic [SB_IDX_W-1:0] regIdx;
    logic                dataBit;
  } bankStrobeT;
endpackage

// File: rtl/serialShiftCtrl.sv
module serialShiftCtrl
  import serialBankPkg::*;
#(
  parameter int unsigned REG_W = SB_REG_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [SB_IDX_W-1:0] wrIdx,
  input  logic                wrAbort,
  input  logic                wrBit,
  input  logic                modeActive,
  input  logic                modeWrEn,
  input  logic                modeWrA0,
  output bankStrobeT          strb
);
  localparam logic [SB_CNT_W-1:0] LAST_POS = SB_CNT_W'(REG_W - 1);

  logic [SB_CNT_W-1:0] bitCnt;
  logic hardClr, wrLive, softRst, shiftEn, commit;

  // mode write with A0 outranks any data write in the same cycle
  assign hardClr = modeWrEn && modeWrA0;
  assign wrLive  = busWrEn && modeActive && !hardClr;
  assign softRst = wrLive && wrAbort;
  assign shiftEn = wrLive && !wrAbort;
  assign commit  = shiftEn && (bitCnt == LAST_POS);

  always_ff @(posedge clk) begin
    if (!rstN)                          bitCnt <= '0;
    else if (hardClr || softRst || commit) bitCnt <= '0;
    else if (shiftEn)                   bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    strb.hardClr = hardClr;
    strb.softRst = softRst;
    strb.shiftEn = shiftEn;
    strb.commit  = commit;
    strb.bitPos  = bitCnt;
    strb.regIdx  = wrIdx;
    strb.dataBit = wrBit;
  end
endmodule

// File: rtl/bankRegDatapath.sv
module bankRegDatapath
  import serialBankPkg::*;
#(
  parameter int unsigned REG_W = SB_REG_W,
  parameter int unsigned NREGS = SB_NREGS
) (
  input  logic             clk,
  input  logic             rstN,
  input  bankStrobeT       strb,
  output logic             prgIs32k,
  output logic [2:0]       prg32kBank,
  output logic [3:0]       prgLoBank,
  output logic [3:0]       prgHiBank,
  output logic             patIs4k,
  output logic [3:0]       pat8kBank,
  output logic [REG_W-1:0] patLoBank,
  output logic [REG_W-1:0] patHiBank,
  output logic [1:0]       mirrorSel
);
  localparam int unsigned BUF_W   = REG_W - 1;
  localparam int unsigned PRG_IDX = NREGS - 1;

  logic [BUF_W-1:0] shiftBuf;
  logic [REG_W-1:0] commitVal;
  logic [NREGS-1:0][REG_W-1:0] regVec;

  assign commitVal = {strb.dataBit, shiftBuf};

  always_ff @(posedge clk) begin
    if (!rstN) shiftBuf <= '0;
    else if (strb.hardClr || strb.softRst || strb.commit) shiftBuf <= '0;
    else if (strb.shiftEn) begin
      for (int i = 0; i < BUF_W; i++)
        if (strb.bitPos == SB_CNT_W'(i)) shiftBuf[i] <= strb.dataBit;
    end
  end

  for (genvar g = 0; g < NREGS; g++) begin : gReg
    localparam logic [REG_W-1:0] RST_VAL = (g == 0) ? SB_CTRL_RST : '0;
    logic [REG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) q <= RST_VAL;
      else if (strb.hardClr) begin
        if (g == 0)            q <= SB_CTRL_RST;
        else if (g == PRG_IDX) q <= '0;
      end else if (strb.softRst && g == 0) q <= q | SB_CTRL_RST;
      else if (strb.commit && strb.regIdx == SB_IDX_W'(g)) q <= commitVal;
    end
    assign regVec[g] = q;
  end

  logic [REG_W-1:0] ctrlR, patLoR, patHiR, prgR;
  logic [3:0] prgBank;
  assign ctrlR   = regVec[0];
  assign patLoR  = regVec[1];
  assign patHiR  = regVec[2];
  assign prgR    = regVec[PRG_IDX];
  assign prgBank = prgR[3:0];

  logic unusedPrgTop;
  assign unusedPrgTop = prgR[REG_W-1];

  always_comb begin
    prgIs32k   = !ctrlR[3];
    prg32kBank = prgBank[3:1];
    if (!ctrlR[3]) begin
      prgLoBank = {prgBank[3:1], 1'b0};
      prgHiBank = {prgBank[3:1], 1'b1};
    end else if (ctrlR[2]) begin
      prgLoBank = prgBank;
      prgHiBank = 4'hF;
    end else begin
      prgLoBank = 4'h0;
      prgHiBank = prgBank;
    end
    patIs4k   = ctrlR[4];
    pat8kBank = patLoR[REG_W-1:1];
    if (ctrlR[4]) begin
      patLoBank = patLoR;
      patHiBank = patHiR;
    end else begin
      patLoBank = {patLoR[REG_W-1:1], 1'b0};
      patHiBank = {patLoR[REG_W-1:1], 1'b1};
    end
    mirrorSel = ctrlR[1:0];
  end
endmodule

// File: rtl/serialBankRegs.sv
module serialBankRegs
  import serialBankPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic [15:0] busAddr,
  input  logic [7:0]  busData,
  input  logic [1:0]  modeSel,
  input  logic        modeWrEn,
  input  logic        modeWrA0,
  output logic        prgIs32k,
  output logic [2:0]  prg32kBank,
  output logic [3:0]  prgLoBank,
  output logic [3:0]  prgHiBank,
  output logic        patIs4k,
  output logic [3:0]  pat8kBank,
  output logic [4:0]  patLoBank,
  output logic [4:0]  patHiBank,
  output logic [1:0]  mirrorSel
);
  bankStrobeT strb;

  logic unusedInBits;
  assign unusedInBits = ^{busAddr[15], busAddr[12:0], busData[6:1], modeSel[0]};

  serialShiftCtrl #(.REG_W(SB_REG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn),
    .wrIdx(busAddr[14:13]), .wrAbort(busData[7]), .wrBit(busData[0]),
    .modeActive(modeSel[1]), .modeWrEn(modeWrEn), .modeWrA0(modeWrA0),
    .strb(strb)
  );

  bankRegDatapath #(.REG_W(SB_REG_W), .NREGS(SB_NREGS)) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .prgIs32k(prgIs32k), .prg32kBank(prg32kBank),
    .prgLoBank(prgLoBank), .prgHiBank(prgHiBank),
    .patIs4k(patIs4k), .pat8kBank(pat8kBank),
    .patLoBank(patLoBank), .patHiBank(patHiBank),
    .mirrorSel(mirrorSel)
  );
endmodule

// File: rtl/serialBankRegsChk.sv
module serialBankRegsChk (
  input logic        clk,
  input logic        rstN,
  input logic        busWrEn,
  input logic [15:0] busAddr,
  input logic [7:0]  busData,
  input logic [1:0]  modeSel,
  input logic        modeWrEn,
  input logic        modeWrA0,
  input logic        prgIs32k,
  input logic [2:0]  prg32kBank,
  input logic [3:0]  prgLoBank,
  input logic [3:0]  prgHiBank,
  input logic        patIs4k,
  input logic [3:0]  pat8kBank,
  input logic [4:0]  patLoBank,
  input logic [4:0]  patHiBank,
  input logic [1:0]  mirrorSel
);
  logic [28:0] outVec;
  assign outVec = {prgIs32k, prg32kBank, prgLoBank, prgHiBank, patIs4k,
                   pat8kBank, patLoBank, patHiBank, mirrorSel};

  logic unusedAddr;
  assign unusedAddr = ^busAddr;

  // R9
  hard_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeWrEn && modeWrA0) |=> (!prgIs32k && prgLoBank == 4'h0 &&
                                prgHiBank == 4'hF && !patIs4k && mirrorSel == 2'b00));

  // R2
  abort_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && modeSel[1] && busData[7] && !(modeWrEn && modeWrA0)) |=>
      (!prgIs32k && prgHiBank == 4'hF && $stable(mirrorSel) && $stable(patIs4k)
       && $stable(patLoBank) && $stable(patHiBank)));

  // R10
  idle_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !modeSel[1] && !modeWrEn) |=> $stable(outVec));

  // R3
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrEn && !modeWrEn) |=> $stable(outVec));

  // R5
  wide_prg_chk: assert property (@(posedge clk) disable iff (!rstN)
    prgIs32k |-> (prgLoBank == {prg32kBank, 1'b0} && prgHiBank == {prg32kBank, 1'b1}));

  // R7
  wide_pat_chk: assert property (@(posedge clk) disable iff (!rstN)
    !patIs4k |-> (patLoBank == {pat8kBank, 1'b0} && patHiBank == {pat8kBank, 1'b1}));
endmodule

bind serialBankRegs serialBankRegsChk chk (.*);

// File: tb/tb_serialBankRegs.sv
module tb_serialBankRegs;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0] busData = '0;
  logic [1:0] modeSel = 2'd2;
  logic modeWrEn = 1'b0;
  logic modeWrA0 = 1'b0;
  logic prgIs32k, patIs4k;
  logic [2:0] prg32kBank;
  logic [3:0] prgLoBank, prgHiBank, pat8kBank;
  logic [4:0] patLoBank, patHiBank;
  logic [1:0] mirrorSel;

  always #(CLK_PERIOD/2) clk = ~clk;

  serialBankRegs dut (.*);

  typedef struct {
    logic [28:0] vec;
    string       tag;
  } expItemT;

  expItemT sbQ[$];
  int checks = 0;
  int errors = 0;

  // bench model of the register state, from the requirements
  logic [4:0] mReg [4];
  logic [4:0] mBuf;
  int mCnt;

  function automatic logic [28:0] expOut();
    logic [4:0] c;
    logic [3:0] b, lo, hi;
    logic [4:0] plo, phi;
    c = mReg[0];
    b = mReg[3][3:0];
    if (!c[3])    begin lo = {b[3:1], 1'b0}; hi = {b[3:1], 1'b1}; end
    else if (c[2]) begin lo = b; hi = 4'hF; end
    else           begin lo = 4'h0; hi = b; end
    if (c[4]) begin plo = mReg[1]; phi = mReg[2]; end
    else      begin plo = {mReg[1][4:1], 1'b0}; phi = {mReg[1][4:1], 1'b1}; end
    return {!c[3], b[3:1], lo, hi, c[4], mReg[1][4:1], plo, phi, c[1:0]};
  endfunction

  task automatic step(input logic we, input logic [15:0] a, input logic [7:0] d,
                      input logic mw, input logic ma0, input string tag);
    expItemT it;
    busWrEn = we; busAddr = a; busData = d; modeWrEn = mw; modeWrA0 = ma0;
    @(posedge clk);
    if (mw && ma0) begin
      mReg[0] = 5'h0C; mReg[3] = 5'h00; mBuf = '0; mCnt = 0;
    end else if (we && modeSel[1]) begin
      if (d[7]) begin
        mBuf = '0; mCnt = 0; mReg[0] = mReg[0] | 5'h0C;
      end else begin
        mBuf[mCnt] = d[0];
        mCnt++;
        if (mCnt == 5) begin
          mReg[a[14:13]] = mBuf; mBuf = '0; mCnt = 0;
        end
      end
    end
    it.vec = expOut(); it.tag = tag;
    sbQ.push_back(it);
    @(negedge clk);
    busWrEn = 1'b0; modeWrEn = 1'b0; modeWrA0 = 1'b0;
  endtask

  task automatic sendBit(input logic [15:0] a, input logic b, input string tag);
    step(1'b1, a, {1'b0, 6'h2A, b}, 1'b0, 1'b0, tag);
  endtask

  task automatic sendReg(input logic [15:0] a, input logic [4:0] v, input string tag);
    for (int i = 0; i < 5; i++) sendBit(a, v[i], tag);
  endtask

  // monitor: compare each expected item one half-cycle after its edge
  always @(negedge clk) begin
    if (rstN && sbQ.size() > 0) begin
      expItemT it;
      logic [28:0] act;
      it = sbQ.pop_front();
      act = {prgIs32k, prg32kBank, prgLoBank, prgHiBank, patIs4k, pat8kBank,
             patLoBank, patHiBank, mirrorSel};
      checks++;
      if (act !== it.vec) begin
        errors++;
        $display("FAIL %s act %h exp %h", it.tag, act, it.vec);
      end
    end
  end

  initial begin
    mReg[0] = 5'h0C; mReg[1] = '0; mReg[2] = '0; mReg[3] = '0;
    mBuf = '0; mCnt = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(1'b0, 16'h0, 8'h0, 1'b0, 1'b0, "R1 reset state");

    sendReg(16'h8000, 5'h1E, "R3 R4 R7 R8 control load");
    sendReg(16'hE000, 5'h0B, "R4 R6 fixed high window");
    sendReg(16'hA000, 5'h13, "R4 R7 pattern low reg");
    sendReg(16'hC000, 5'h0A, "R4 R7 pattern high reg");
    sendReg(16'h8000, 5'h13, "R5 R8 32K window");
    sendReg(16'h8000, 5'h09, "R6 R7 R8 fixed low window, 8K pattern");

    // abort mid-load, then a full load must land cleanly
    sendBit(16'h8000, 1'b0, "R2 partial");
    sendBit(16'h8000, 1'b1, "R2 partial");
    sendBit(16'h8000, 1'b1, "R2 partial");
    step(1'b1, 16'h8000, 8'h80, 1'b0, 1'b0, "R2 abort sets bits 2,3");
    sendReg(16'h8000, 5'h12, "R2 load after abort");

    // mode write without A0 mid-load has no effect
    sendBit(16'hE000, 1'b1, "R9 partial");
    sendBit(16'hE000, 1'b0, "R9 partial");
    step(1'b0, 16'h0, 8'h0, 1'b1, 1'b0, "R9 mode write A0=0");
    sendBit(16'hE000, 1'b1, "R9 finish");
    sendBit(16'hE000, 1'b1, "R9 finish");
    sendBit(16'hE000, 1'b0, "R9 finish");

    // mode write with A0 mid-load clears state
    sendBit(16'hE000, 1'b1, "R9 partial");
    sendBit(16'hE000, 1'b1, "R9 partial");
    step(1'b0, 16'h0, 8'h0, 1'b1, 1'b1, "R9 mode write A0=1");
    sendReg(16'hE000, 5'h05, "R9 load after hard clear");
    sendReg(16'h8000, 5'h1B, "R9 control after hard clear");

    // ignored writes in modes 1 and 0
    modeSel = 2'd1;
    sendBit(16'h8000, 1'b1, "R10 mode1 bit");
    sendBit(16'h8000, 1'b0, "R10 mode1 bit");
    step(1'b1, 16'h8000, 8'h80, 1'b0, 1'b0, "R10 mode1 abort");
    modeSel = 2'd0;
    sendReg(16'hA000, 5'h1F, "R10 mode0 load");
    modeSel = 2'd3;
    sendReg(16'hA000, 5'h06, "R10 mode3 load after ignored writes");

    // same-cycle hard clear and data write
    sendBit(16'hE000, 1'b1, "R11 partial");
    step(1'b1, 16'hE000, 8'h01, 1'b1, 1'b1, "R11 collision");
    sendReg(16'hE000, 5'h0E, "R11 load after collision");

    step(1'b0, 16'h0, 8'h0, 1'b0, 1'b0, "R3 idle hold");
    @(negedge clk);
    if (sbQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard act %0d exp 0 items left", sbQ.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule